// File: doc/BRIEF.md
# Instrument Status Reporting Register Set

This block keeps the status registers of a measurement instrument. Three register groups (standard event, operation and error) each watch an 8-bit vector of live condition inputs. Each group shows the live condition word, latches rising condition edges into an event word, and masks the event word with a writable enable word to form one summary bit. The three summary bits make up a status byte. A service-request enable word masks that byte to produce a service-request flag, which also shows up in the byte itself.

Software reaches the registers through a small access port. The port has a read strobe, a write strobe, a 4-bit address, write data and read data. The read data is combinational and follows the address. A read of an event word returns its contents and empties it at the same clock edge. Only the enable words can be written. A clear-all strobe empties all three event words together. Every register holds a plain binary value in which bit n carries weight 2^n.

Top module: `status_regs_top`

## Requirements
- R1: After reset the event words, the enable words, the status byte and the service-request flag are all zero.
- R2: A read of a condition address (0 standard, 3 operation, 6 error) returns the live condition input with bit n weighted 2^n. For example, bits 0, 2 and 4 set read as 21.
- R3: A 0-to-1 change of a condition bit between two clock edges sets the matching event bit. The bit then stays set while the condition falls or stays high, until it is cleared.
- R4: A read of an event address (1 standard, 4 operation, 7 error) returns the event word and clears it at that clock edge. If a new rising condition edge lands in the same cycle, that bit is set afterwards.
- R5: One cycle of the clear-all strobe empties all three event words and leaves every enable word unchanged.
- R6: A write to an enable address (2, 5, 8 standard/operation/error, 10 service request) loads that word, and writing 0 clears it. Writes to any other address change no register.
- R7: Status byte bit 5 is the OR of (standard event AND its enable), bit 7 is the same for the operation group, and bit 2 is the same for the error group. Bits 0, 1, 3 and 4 read 0.
- R8: The status byte (address 9) does not latch. A summary bit drops as soon as its event word is cleared, and reading the byte clears nothing.
- R9: The service-request flag is the OR of (status byte AND service-request enable) with bit 6 excluded, and it appears as status byte bit 6.
- R10: Reads of the unmapped addresses 11 to 15 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| std_cond_i | input | 8 | Standard event condition inputs |
| oper_cond_i | input | 8 | Operation condition inputs |
| err_cond_i | input | 8 | Error condition inputs |
| acc_rd_i | input | 1 | Read strobe (clears an addressed event word) |
| acc_wr_i | input | 1 | Write strobe |
| acc_addr_i | input | 4 | Register address |
| acc_wdata_i | input | 8 | Write data |
| acc_rdata_o | output | 8 | Read data for the addressed register |
| clr_all_i | input | 1 | Clear all event words |
| stb_o | output | 8 | Status byte |
| srq_o | output | 1 | Service-request flag |

## Verification
On every cycle, the assertions check that a rising edge latches, that event bits hold without a clear, that a clear with no new edge empties the word, that enable words load on a write and hold otherwise, that the unused status byte bits stay at zero, and that the request flag always has an enabled source. Some behaviours are visible only through the bench's scenarios, which compare the port against a reference model. These are the clear-on-read ordering against a coincident edge, the isolation of clear-all from the enable words, writes ignored at read-only addresses, and the non-latching status byte following event clears.

// File: rtl/status_pkg.sv
package status_pkg;
  localparam int REG_W   = 8;
  localparam int ADDR_W  = 4;
  localparam int NGRP    = 3;
  localparam int GRP_STD = 0;
  localparam int GRP_OPR = 1;
  localparam int GRP_ERR = 2;
  // status byte bit positions
  localparam int SB_STD  = 5;
  localparam int SB_OPR  = 7;
  localparam int SB_ERR  = 2;
  localparam int SB_RQS  = 6;
  // address map: group g uses 3g (condition), 3g+1 (event), 3g+2 (enable)
  localparam int ADDR_STB = 9;
  localparam int ADDR_SRE = 10;

  typedef enum logic [1:0] {
    SEL_COND = 2'd0,
    SEL_EVT  = 2'd1,
    SEL_EN   = 2'd2
  } grp_sel_e;
endpackage

// File: rtl/status_group.sv
module status_group #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cond_i,
  input  logic         clr_ev_i,
  input  logic         en_wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] ev_o,
  output logic [W-1:0] en_o,
  output logic         sum_o
);
  logic [W-1:0] prev_q, ev_q, en_q;
  logic [W-1:0] rise, ev_d;

  always_comb begin
    rise = cond_i & ~prev_q;
    ev_d = (clr_ev_i ? '0 : ev_q) | rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      ev_q   <= '0;
      en_q   <= '0;
    end else begin
      prev_q <= cond_i;
      ev_q   <= ev_d;
      if (en_wr_i) en_q <= wdata_i;
    end
  end

  assign ev_o  = ev_q;
  assign en_o  = en_q;
  assign sum_o = |(ev_q & en_q);

  p_rise_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((ev_o & $past(rise)) == $past(rise)));
  p_event_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_ev_i |=> ((ev_o & $past(ev_o)) == $past(ev_o)));
  p_clear_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ev_i && rise == '0) |=> (ev_o == '0));
  p_en_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr_i |=> (en_o == $past(wdata_i)));
  p_en_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !en_wr_i |=> $stable(en_o));
endmodule

// File: rtl/status_summary.sv
module status_summary
  import status_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NGRP-1:0]  grp_sum_i,
  input  logic             sre_wr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] sre_o,
  output logic [REG_W-1:0] stb_o,
  output logic             srq_o
);
  localparam logic [REG_W-1:0] RQS_MASK = REG_W'(1) << SB_RQS;

  logic [REG_W-1:0] sre_q, base;
  logic             srq;

  always_comb begin
    base          = '0;
    base[SB_STD]  = grp_sum_i[GRP_STD];
    base[SB_OPR]  = grp_sum_i[GRP_OPR];
    base[SB_ERR]  = grp_sum_i[GRP_ERR];
    srq           = |(base & sre_q & ~RQS_MASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sre_q <= '0;
    else if (sre_wr_i) sre_q <= wdata_i;
  end

  assign sre_o = sre_q;
  assign stb_o = base | (srq ? RQS_MASK : '0);
  assign srq_o = srq;

  p_srq_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    srq_o |-> (|(stb_o & sre_o & ~RQS_MASK)));
  p_sre_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sre_wr_i |=> $stable(sre_o));
endmodule

// File: rtl/status_regs_top.sv
module status_regs_top
  import status_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_W-1:0]  std_cond_i,
  input  logic [REG_W-1:0]  oper_cond_i,
  input  logic [REG_W-1:0]  err_cond_i,
  input  logic              acc_rd_i,
  input  logic              acc_wr_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [REG_W-1:0]  acc_wdata_i,
  output logic [REG_W-1:0]  acc_rdata_o,
  input  logic              clr_all_i,
  output logic [REG_W-1:0]  stb_o,
  output logic              srq_o
);
  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [NGRP-1:0][REG_W-1:0] cond, ev, en;
  logic [NGRP-1:0]            clr_ev, en_wr, grp_sum;
  logic [REG_W-1:0]           sre, stb;
  logic                       sre_wr;

  assign cond[GRP_STD] = std_cond_i;
  assign cond[GRP_OPR] = oper_cond_i;
  assign cond[GRP_ERR] = err_cond_i;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam logic [ADDR_W-1:0] A_EVT = ADDR_W'(3*g + int'(SEL_EVT));
    localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(3*g + int'(SEL_EN));

    assign clr_ev[g] = clr_all_i | (acc_rd_i && acc_addr_i == A_EVT);
    assign en_wr[g]  = acc_wr_i && acc_addr_i == A_EN;

    status_group #(.W(REG_W)) u_grp (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .cond_i   (cond[g]),
      .clr_ev_i (clr_ev[g]),
      .en_wr_i  (en_wr[g]),
      .wdata_i  (acc_wdata_i),
      .ev_o     (ev[g]),
      .en_o     (en[g]),
      .sum_o    (grp_sum[g])
    );
  end

  assign sre_wr = acc_wr_i && acc_addr_i == ADDR_W'(ADDR_SRE);

  status_summary u_sum (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .grp_sum_i (grp_sum),
    .sre_wr_i  (sre_wr),
    .wdata_i   (acc_wdata_i),
    .sre_o     (sre),
    .stb_o     (stb),
    .srq_o     (srq_o)
  );

  always_comb begin
    acc_rdata_o = '0;
    for (int g = 0; g < NGRP; g++) begin
      if (acc_addr_i == ADDR_W'(3*g + int'(SEL_COND))) acc_rdata_o = cond[g];
      if (acc_addr_i == ADDR_W'(3*g + int'(SEL_EVT)))  acc_rdata_o = ev[g];
      if (acc_addr_i == ADDR_W'(3*g + int'(SEL_EN)))   acc_rdata_o = en[g];
    end
    if (acc_addr_i == ADDR_W'(ADDR_STB)) acc_rdata_o = stb;
    if (acc_addr_i == ADDR_W'(ADDR_SRE)) acc_rdata_o = sre;
  end

  assign stb_o = stb;

  p_unused_zero_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (stb_o[0] | stb_o[1] | stb_o[3] | stb_o[4]) == 1'b0);
endmodule

// File: tb/sim_status_regs_top.sv
module sim_status_regs_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] c_std, c_opr, c_err;
  logic       rd, wr, clr;
  logic [3:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata, stb;
  logic       srq;

  int checks = 0;
  int fails  = 0;

  logic [7:0] m_ev[3], m_en[3], m_prev[3], m_sre;

  always #10 clk = ~clk;

  status_regs_top u0 (
    .clk(clk), .rst_n(rst_n),
    .std_cond_i(c_std), .oper_cond_i(c_opr), .err_cond_i(c_err),
    .acc_rd_i(rd), .acc_wr_i(wr), .acc_addr_i(addr),
    .acc_wdata_i(wdata), .acc_rdata_o(rdata),
    .clr_all_i(clr), .stb_o(stb), .srq_o(srq)
  );

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] cur_cond(int g);
    return (g == 0) ? c_std : (g == 1) ? c_opr : c_err;
  endfunction

  function automatic logic [7:0] exp_base();
    logic [7:0] b = '0;
    b[5] = |(m_ev[0] & m_en[0]);
    b[7] = |(m_ev[1] & m_en[1]);
    b[2] = |(m_ev[2] & m_en[2]);
    return b;
  endfunction

  function automatic logic exp_srq();
    return |(exp_base() & m_sre & 8'hBF);
  endfunction

  function automatic logic [7:0] exp_stb();
    return exp_base() | (exp_srq() ? 8'h40 : 8'h00);
  endfunction

  function automatic logic [7:0] exp_rd(logic [3:0] a);
    if (a < 4'd9) begin
      case (a % 3)
        0:       return cur_cond(a / 3);
        1:       return m_ev[a / 3];
        default: return m_en[a / 3];
      endcase
    end
    if (a == 4'd9)  return exp_stb();
    if (a == 4'd10) return m_sre;
    return 8'h00;
  endfunction

  function automatic string rd_tag(logic [3:0] a);
    if (a < 4'd9) return (a % 3 == 0) ? "R2" : (a % 3 == 1) ? "R4" : "R6";
    if (a == 4'd9)  return "R8";
    if (a == 4'd10) return "R6";
    return "R10";
  endfunction

  // one cycle: drive, check combinational outputs, clock, update model
  task automatic step(logic [7:0] s, logic [7:0] o, logic [7:0] e,
                      logic r, logic w, logic cl, logic [3:0] a,
                      logic [7:0] d, string tag = "");
    c_std = s; c_opr = o; c_err = e;
    rd = r; wr = w; clr = cl; addr = a; wdata = d;
    #1;
    if (r) chk((tag == "") ? rd_tag(a) : tag, rdata, exp_rd(a));
    chk("R7", stb, exp_stb());
    chk("R9", {7'd0, srq}, {7'd0, exp_srq()});
    @(posedge clk);
    for (int g = 0; g < 3; g++) begin
      logic [7:0] cv = cur_cond(g);
      logic clr_g = cl | (r && a == 4'(3*g + 1));
      m_ev[g]   = (clr_g ? 8'h00 : m_ev[g]) | (cv & ~m_prev[g]);
      m_prev[g] = cv;
      if (w && a == 4'(3*g + 2)) m_en[g] = d;
    end
    if (w && a == 4'd10) m_sre = d;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd24681));
    rst_n = 1'b0;
    c_std = 0; c_opr = 0; c_err = 0;
    rd = 0; wr = 0; clr = 0; addr = 0; wdata = 0;
    for (int g = 0; g < 3; g++) begin m_ev[g] = 0; m_en[g] = 0; m_prev[g] = 0; end
    m_sre = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    chk("R1", stb, 8'h00);
    chk("R1", {7'd0, srq}, 8'h00);
    for (int a = 1; a <= 10; a++) step(0, 0, 0, 1, 0, 0, 4'(a), 0, "R1");

    // R2: weighting example, bits 0,2,4 -> 21
    step(8'h15, 0, 0, 1, 0, 0, 4'd0, 0, "R2");
    chk("R2", rdata, 8'd21);
    // R3: event latched and held after condition drops
    step(0, 0, 0, 0, 0, 0, 4'd0, 0);
    step(0, 0, 0, 1, 0, 0, 4'd9, 0, "R8");
    step(0, 0, 0, 1, 0, 0, 4'd1, 0, "R3");
    // R4: cleared by the read above
    step(0, 0, 0, 1, 0, 0, 4'd1, 0, "R4");
    // R4: read coinciding with a rising edge keeps the new bit
    step(8'h01, 0, 0, 0, 0, 0, 4'd0, 0);
    step(8'h03, 0, 0, 1, 0, 0, 4'd1, 0, "R4");
    step(8'h03, 0, 0, 1, 0, 0, 4'd1, 0, "R4");

    // R7/R8/R9: enable std summary, request, then clear by reading events
    step(0, 0, 0, 0, 1, 0, 4'd2, 8'hFF);
    step(0, 0, 0, 0, 1, 0, 4'd10, 8'hFF);
    step(0, 8'h80, 8'h10, 0, 1, 0, 4'd5, 8'h80);
    step(0, 0, 0, 0, 1, 0, 4'd8, 8'h10);
    step(8'h04, 0, 0, 1, 0, 0, 4'd9, 0, "R8");
    chk("R9", {7'd0, srq}, 8'h01);
    chk("R7", stb, 8'hE4);
    step(0, 0, 0, 1, 0, 0, 4'd4, 0, "R8");
    chk("R8", stb, 8'h64);

    // R6: writes to read-only addresses are ignored
    step(8'h20, 8'h01, 0, 0, 1, 0, 4'd1, 8'h00);
    step(8'h20, 8'h01, 0, 0, 1, 0, 4'd9, 8'h00);
    step(8'h20, 8'h01, 0, 0, 1, 0, 4'd0, 8'h00);
    step(8'h20, 8'h01, 0, 1, 0, 0, 4'd1, 0, "R6");
    step(8'h20, 8'h01, 0, 1, 0, 0, 4'd2, 0, "R6");

    // R5: clear-all empties events, keeps enables
    step(8'hA0, 8'h05, 8'h30, 0, 0, 0, 4'd0, 0);
    step(8'hA0, 8'h05, 8'h30, 0, 0, 1, 4'd0, 0);
    for (int a = 1; a <= 10; a++) step(8'hA0, 8'h05, 8'h30, 1, 0, 0, 4'(a), 0, "R5");

    // R6: write zero clears an enable
    step(0, 0, 0, 0, 1, 0, 4'd2, 8'h00);
    step(0, 0, 0, 1, 0, 0, 4'd2, 0, "R6");

    // R10: unmapped reads
    for (int a = 11; a <= 15; a++) step(0, 0, 0, 1, 0, 0, 4'(a), 0, "R10");

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      int sel = $urandom_range(0, 99);
      logic r  = sel < 40;
      logic w  = (sel >= 40) && (sel < 60);
      logic cl = sel >= 95;
      step(8'($urandom), 8'($urandom), 8'($urandom), r, w, cl,
           4'($urandom_range(0, 15)), 8'($urandom));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule